// File: doc/BRIEF.md
# Exception Entry Sequencer

This block turns a raised exception into the register updates a processor core needs at exception entry. The core presents a one-cycle strobe with an exception kind, the PC of the faulting instruction, a flag saying whether that instruction sits in a branch delay slot, a refill flag for TLB misses, a coprocessor number, and the current status, cause and exception-base register values. One clock later the block presents the new program counter, the saved return address, the updated status and cause words, and a one-cycle entry pulse.

Two entry paths exist. General exceptions write an exception code into the cause word. They vector to a base selected by the bootstrap bit, with an offset chosen by the exception kind. They save the return address only when the exception-level flag is clear. Non-maskable interrupts and soft resets take the error-level path instead. That path saves the return address in a separate error register, raises the error-level and bootstrap bits together with a kind-specific status bit, and jumps to the fixed boot vector.

The output registers hold their values between strobes. The core treats them as the architectural values after entry.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, pc_out is 0xBFC00000, epc_out, errorepc_out, status_out and cause_out are zero, and entry_valid is low.
- R2: Recognised exc_kind values are 0 to 13 and 15, which are general kinds whose value is the exception code, plus 28 (NMI) and 29 (soft reset). entry_valid pulses high in the cycle after an exc_valid strobe that carries a recognised kind. A strobe with any other kind is ignored: entry_valid stays low and every output holds its value.
- R3: For a general kind, cause_out equals cause_in, except that bits 6:2 carry the kind value, and except for the BD and CE updates in R8 and R10.
- R4: A general kind vectors to base + 0x180 unless R5 or R6 selects another offset.
- R5: Kind 0 (interrupt) with cause_in bit 23 set uses offset 0x200 instead.
- R6: Kind 2 (TLB load) or kind 3 (TLB store) with exc_refill set, while status_in bit 1 (EXL) is clear, uses offset 0x000. With EXL set, the offset is 0x180.
- R7: The base is 0xBFC00200 when status_in bit 22 (BEV) is set. Otherwise it is ebase_in with bits 9:0 cleared.
- R8: For a general kind with EXL clear, epc_out becomes exc_pc−4 when exc_in_delay is set and exc_pc otherwise. cause bit 31 (BD) becomes exc_in_delay, and status_out is status_in with bit 1 set.
- R9: For a general kind with EXL set, epc_out holds its value, cause bit 31 keeps the cause_in value, and status_out equals status_in.
- R10: Kind 11 (coprocessor unusable) writes exc_cop into cause bits 29:28. Every other kind leaves those bits as in cause_in.
- R11: Kind 28 (NMI) sets status bits 19, 2 (ERL) and 22 (BEV) on top of status_in. errorepc_out gets exc_pc, or exc_pc−4 in a delay slot. pc_out becomes 0xBFC00000, epc_out holds, and cause_out equals cause_in.
- R12: Kind 29 (soft reset) behaves as R11, but sets status bit 20 in place of bit 19.
- R13: Without a strobe, every output holds its value and entry_valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_valid | input | 1 | One-cycle exception strobe |
| exc_kind | input | 5 | Exception kind code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| exc_refill | input | 1 | TLB exception is a refill (no matching entry) |
| exc_cop | input | 2 | Coprocessor number for coprocessor-unusable |
| status_in | input | 32 | Current status register |
| cause_in | input | 32 | Current cause register |
| ebase_in | input | 32 | Exception base register |
| entry_valid | output | 1 | Entry results updated this cycle |
| pc_out | output | 32 | New program counter |
| epc_out | output | 32 | Exception return address |
| errorepc_out | output | 32 | Error-level return address |
| status_out | output | 32 | Updated status register |
| cause_out | output | 32 | Updated cause register |

## Verification
Directed strobes pair each vector offset with each base source. Interrupts are sent with and without the vector bit, and TLB kinds with the refill flag and with both EXL states, so that a wrong offset selection shows up as a distinct wrong PC. Delay-slot and non-delay faults are each taken with EXL clear and with EXL set: a held EPC is told apart from a freshly written one, and a preserved BD bit from a rewritten one. The two error-level kinds are told apart by their status bit. Unrecognised kinds, coprocessor numbers with distinct CE field patterns, and a run of randomised general exceptions with random cause and status backgrounds show whether untouched bits survive.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int KIND_W = 5;

   typedef enum logic [KIND_W-1:0] {
      K_INT     = 5'd0,
      K_TLB_MOD = 5'd1,
      K_TLB_LD  = 5'd2,
      K_TLB_ST  = 5'd3,
      K_ADE_LD  = 5'd4,
      K_ADE_ST  = 5'd5,
      K_IBUS    = 5'd6,
      K_DBUS    = 5'd7,
      K_SYSC    = 5'd8,
      K_BRK     = 5'd9,
      K_RSVD    = 5'd10,
      K_COPU    = 5'd11,
      K_OVF     = 5'd12,
      K_TRAP    = 5'd13,
      K_FPE     = 5'd15,
      K_NMI     = 5'd28,
      K_SRST    = 5'd29
   } exc_kind_e;

   // general kinds: the kind value is the exception code written to cause
   function automatic logic kind_general(input logic [KIND_W-1:0] k);
      logic r;
      case (k)
         K_INT, K_TLB_MOD, K_TLB_LD, K_TLB_ST, K_ADE_LD, K_ADE_ST,
         K_IBUS, K_DBUS, K_SYSC, K_BRK, K_RSVD, K_COPU, K_OVF,
         K_TRAP, K_FPE: r = 1'b1;
         default:       r = 1'b0;
      endcase
      return r;
   endfunction

   function automatic logic kind_errlvl(input logic [KIND_W-1:0] k);
      return (k == K_NMI) || (k == K_SRST);
   endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
   import exc_entry_pkg::*;
#(
   parameter int                XLEN       = 32,
   parameter int                ALIGN_BITS = 10,
   parameter int                OFF_W      = 12,
   parameter logic [XLEN-1:0]   BEV_BASE   = 32'hBFC0_0200,
   parameter logic [OFF_W-1:0]  OFF_GEN    = 12'h180,
   parameter logic [OFF_W-1:0]  OFF_IRQV   = 12'h200,
   parameter logic [OFF_W-1:0]  OFF_REFILL = 12'h000
) (
   input  logic [KIND_W-1:0] kind,
   input  logic              refill,
   input  logic              exl,
   input  logic              bev,
   input  logic              irq_vec,
   input  logic [XLEN-1:0]   ebase,
   output logic [XLEN-1:0]   target
);

   logic [XLEN-1:0]  soft_base;
   logic [XLEN-1:0]  base;
   logic [OFF_W-1:0] off;

   generate
      if (ALIGN_BITS == 0) begin : g_noalign
         assign soft_base = ebase;
      end else begin : g_align
         assign soft_base = {ebase[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end
   endgenerate

   always_comb begin
      off = OFF_GEN;
      if (kind == K_INT && irq_vec) begin
         off = OFF_IRQV;
      end else if ((kind == K_TLB_LD || kind == K_TLB_ST) && refill && !exl) begin
         off = OFF_REFILL;
      end
   end

   assign base   = bev ? BEV_BASE : soft_base;
   assign target = base + XLEN'(off);

endmodule

// File: rtl/exc_state_next.sv
module exc_state_next
   import exc_entry_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int EXL_BIT = 1,
   parameter int ERL_BIT = 2,
   parameter int BEV_BIT = 22,
   parameter int SR_BIT  = 20,
   parameter int NMI_BIT = 19,
   parameter int BD_BIT  = 31,
   parameter int CE_LSB  = 28,
   parameter int EXC_LSB = 2
) (
   input  logic [KIND_W-1:0] kind,
   input  logic [XLEN-1:0]   pc,
   input  logic              in_delay,
   input  logic [1:0]        cop,
   input  logic [XLEN-1:0]   status_in,
   input  logic [XLEN-1:0]   cause_in,
   input  logic [XLEN-1:0]   epc_q,
   input  logic [XLEN-1:0]   errepc_q,
   output logic [XLEN-1:0]   status_nx,
   output logic [XLEN-1:0]   cause_nx,
   output logic [XLEN-1:0]   epc_nx,
   output logic [XLEN-1:0]   errepc_nx
);

   localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

   logic [XLEN-1:0] ret_pc;
   logic            exl;

   assign ret_pc = in_delay ? (pc - INSN_BYTES) : pc;
   assign exl    = status_in[EXL_BIT];

   always_comb begin
      status_nx = status_in;
      cause_nx  = cause_in;
      epc_nx    = epc_q;
      errepc_nx = errepc_q;
      if (kind_errlvl(kind)) begin
         status_nx[ERL_BIT] = 1'b1;
         status_nx[BEV_BIT] = 1'b1;
         if (kind == K_NMI) status_nx[NMI_BIT] = 1'b1;
         else               status_nx[SR_BIT]  = 1'b1;
         errepc_nx = ret_pc;
      end else begin
         cause_nx[EXC_LSB +: KIND_W] = kind;
         if (kind == K_COPU) cause_nx[CE_LSB +: 2] = cop;
         if (!exl) begin
            epc_nx             = ret_pc;
            cause_nx[BD_BIT]   = in_delay;
            status_nx[EXL_BIT] = 1'b1;
         end
      end
   end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int              XLEN       = 32,
   parameter int              EXL_BIT    = 1,
   parameter int              ERL_BIT    = 2,
   parameter int              BEV_BIT    = 22,
   parameter int              SR_BIT     = 20,
   parameter int              NMI_BIT    = 19,
   parameter int              BD_BIT     = 31,
   parameter int              IV_BIT     = 23,
   parameter int              CE_LSB     = 28,
   parameter int              EXC_LSB    = 2,
   parameter int              ALIGN_BITS = 10,
   parameter logic [XLEN-1:0] BOOT_VEC   = 32'hBFC0_0000,
   parameter logic [XLEN-1:0] BEV_BASE   = 32'hBFC0_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [4:0]        exc_kind,
   input  logic [XLEN-1:0]   exc_pc,
   input  logic              exc_in_delay,
   input  logic              exc_refill,
   input  logic [1:0]        exc_cop,
   input  logic [XLEN-1:0]   status_in,
   input  logic [XLEN-1:0]   cause_in,
   input  logic [XLEN-1:0]   ebase_in,
   output logic              entry_valid,
   output logic [XLEN-1:0]   pc_out,
   output logic [XLEN-1:0]   epc_out,
   output logic [XLEN-1:0]   errorepc_out,
   output logic [XLEN-1:0]   status_out,
   output logic [XLEN-1:0]   cause_out
);

   localparam int MAX_BIT = XLEN - 1;

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("exc_entry_seq: XLEN must be at least 32");
      end
      if (EXC_LSB + KIND_W > XLEN || CE_LSB + 2 > XLEN) begin : g_bad_field
         $error("exc_entry_seq: cause field outside register");
      end
      if (BD_BIT > MAX_BIT || IV_BIT > MAX_BIT || BEV_BIT > MAX_BIT ||
          SR_BIT > MAX_BIT || NMI_BIT > MAX_BIT) begin : g_bad_bit
         $error("exc_entry_seq: status or cause bit outside register");
      end
      if (ALIGN_BITS < 0 || ALIGN_BITS >= XLEN) begin : g_bad_align
         $error("exc_entry_seq: ALIGN_BITS out of range");
      end
   endgenerate

   logic            accept;
   logic            errlvl;
   logic [XLEN-1:0] gen_target;
   logic [XLEN-1:0] status_nx, cause_nx, epc_nx, errepc_nx;

   assign errlvl = kind_errlvl(exc_kind);
   assign accept = exc_valid && (kind_general(exc_kind) || errlvl);

   exc_vector_sel #(
      .XLEN       (XLEN),
      .ALIGN_BITS (ALIGN_BITS),
      .BEV_BASE   (BEV_BASE)
   ) u_vec (
      .kind    (exc_kind),
      .refill  (exc_refill),
      .exl     (status_in[EXL_BIT]),
      .bev     (status_in[BEV_BIT]),
      .irq_vec (cause_in[IV_BIT]),
      .ebase   (ebase_in),
      .target  (gen_target)
   );

   exc_state_next #(
      .XLEN    (XLEN),
      .EXL_BIT (EXL_BIT),
      .ERL_BIT (ERL_BIT),
      .BEV_BIT (BEV_BIT),
      .SR_BIT  (SR_BIT),
      .NMI_BIT (NMI_BIT),
      .BD_BIT  (BD_BIT),
      .CE_LSB  (CE_LSB),
      .EXC_LSB (EXC_LSB)
   ) u_next (
      .kind      (exc_kind),
      .pc        (exc_pc),
      .in_delay  (exc_in_delay),
      .cop       (exc_cop),
      .status_in (status_in),
      .cause_in  (cause_in),
      .epc_q     (epc_out),
      .errepc_q  (errorepc_out),
      .status_nx (status_nx),
      .cause_nx  (cause_nx),
      .epc_nx    (epc_nx),
      .errepc_nx (errepc_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_valid  <= 1'b0;
         pc_out       <= BOOT_VEC;
         epc_out      <= '0;
         errorepc_out <= '0;
         status_out   <= '0;
         cause_out    <= '0;
      end else begin
         entry_valid <= accept;
         if (accept) begin
            pc_out       <= errlvl ? BOOT_VEC : gen_target;
            epc_out      <= epc_nx;
            errorepc_out <= errepc_nx;
            status_out   <= status_nx;
            cause_out    <= cause_nx;
         end
      end
   end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
   parameter int              XLEN     = 32,
   parameter int              EXL_BIT  = 1,
   parameter int              ERL_BIT  = 2,
   parameter int              BEV_BIT  = 22,
   parameter logic [XLEN-1:0] BOOT_VEC = 32'hBFC0_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              exc_valid,
   input logic [4:0]        exc_kind,
   input logic [XLEN-1:0]   status_in,
   input logic              entry_valid,
   input logic [XLEN-1:0]   pc_out,
   input logic [XLEN-1:0]   epc_out,
   input logic [XLEN-1:0]   status_out
);

   logic gen_k, err_k;

   always_comb begin
      gen_k = (exc_kind <= 5'd13) || (exc_kind == 5'd15);
      err_k = (exc_kind == 5'd28) || (exc_kind == 5'd29);
   end

   // R2
   entry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      entry_valid == $past(exc_valid && (gen_k || err_k)));

   // R8
   exl_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_valid && $past(gen_k)) |-> status_out[EXL_BIT]);

   // R9
   epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(exc_valid && ((gen_k && status_in[EXL_BIT]) || err_k)) |-> $stable(epc_out));

   // R11
   errlvl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(exc_valid && err_k) |->
         (pc_out == BOOT_VEC && status_out[ERL_BIT] && status_out[BEV_BIT]));

   // R13
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(exc_valid) |-> ($stable(pc_out) && $stable(status_out) && !entry_valid));

endmodule

bind exc_entry_seq exc_entry_chk #(
   .XLEN     (XLEN),
   .EXL_BIT  (EXL_BIT),
   .ERL_BIT  (ERL_BIT),
   .BEV_BIT  (BEV_BIT),
   .BOOT_VEC (BOOT_VEC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exc_valid   (exc_valid),
   .exc_kind    (exc_kind),
   .status_in   (status_in),
   .entry_valid (entry_valid),
   .pc_out      (pc_out),
   .epc_out     (epc_out),
   .status_out  (status_out)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_valid = 1'b0;
   logic [4:0]  exc_kind = '0;
   logic [31:0] exc_pc = '0;
   logic        exc_in_delay = 1'b0;
   logic        exc_refill = 1'b0;
   logic [1:0]  exc_cop = '0;
   logic [31:0] status_in = '0;
   logic [31:0] cause_in = '0;
   logic [31:0] ebase_in = '0;
   logic        entry_valid;
   logic [31:0] pc_out, epc_out, errorepc_out, status_out, cause_out;

   always #10 clk = ~clk;

   exc_entry_seq u_exc_entry_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .exc_valid    (exc_valid),
      .exc_kind     (exc_kind),
      .exc_pc       (exc_pc),
      .exc_in_delay (exc_in_delay),
      .exc_refill   (exc_refill),
      .exc_cop      (exc_cop),
      .status_in    (status_in),
      .cause_in     (cause_in),
      .ebase_in     (ebase_in),
      .entry_valid  (entry_valid),
      .pc_out       (pc_out),
      .epc_out      (epc_out),
      .errorepc_out (errorepc_out),
      .status_out   (status_out),
      .cause_out    (cause_out)
   );

   typedef struct packed {
      logic [31:0] pc;
      logic [31:0] epc;
      logic [31:0] errepc;
      logic [31:0] status;
      logic [31:0] cause;
   } exp_t;

   exp_t  expq[$];
   string tagq[$];
   int    n_tests = 0;
   int    n_fail  = 0;
   bit    finished = 1'b0;

   logic [31:0] m_pc = 32'hBFC0_0000, m_epc = '0, m_errepc = '0, m_status = '0, m_cause = '0;

   task automatic check32(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic report;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic fire(input logic [4:0] k, input logic [31:0] pc, input logic ds,
                       input logic refill, input logic [1:0] cop, input logic [31:0] st,
                       input logic [31:0] ca, input logic [31:0] eb, input string tag);
      exp_t        e;
      logic [31:0] rp, base;
      logic [11:0] off;
      bit          gen, err;
      gen = (k <= 5'd13) || (k == 5'd15);
      err = (k == 5'd28) || (k == 5'd29);
      rp  = ds ? pc - 32'd4 : pc;
      e   = '{pc: m_pc, epc: m_epc, errepc: m_errepc, status: m_status, cause: m_cause};
      if (gen) begin
         off = 12'h180;                                         // R4
         if (k == 5'd0 && ca[23]) off = 12'h200;                // R5
         if ((k == 5'd2 || k == 5'd3) && refill && !st[1]) off = 12'h000; // R6
         base     = st[22] ? 32'hBFC0_0200 : {eb[31:10], 10'b0}; // R7
         e.pc     = base + {20'b0, off};
         e.status = st | 32'h2;
         e.epc    = st[1] ? m_epc : rp;                          // R8 R9
         e.errepc = m_errepc;
         e.cause  = ca;
         e.cause[6:2] = k;                                       // R3
         if (!st[1]) e.cause[31] = ds;
         if (k == 5'd11) e.cause[29:28] = cop;                   // R10
      end else if (err) begin
         e.pc     = 32'hBFC0_0000;
         e.status = st | 32'h0040_0004 | ((k == 5'd28) ? 32'h0008_0000 : 32'h0010_0000);
         e.errepc = rp;
         e.epc    = m_epc;
         e.cause  = ca;
      end
      @(negedge clk);
      exc_kind = k; exc_pc = pc; exc_in_delay = ds; exc_refill = refill;
      exc_cop = cop; status_in = st; cause_in = ca; ebase_in = eb;
      exc_valid = 1'b1;
      if (gen || err) begin
         expq.push_back(e);
         tagq.push_back(tag);
         m_pc = e.pc; m_epc = e.epc; m_errepc = e.errepc;
         m_status = e.status; m_cause = e.cause;
      end
      @(negedge clk);
      exc_valid = 1'b0;
      if (!(gen || err)) begin
         check32(tag, "entry_valid", {31'b0, entry_valid}, 32'd0);
         check32(tag, "pc_out", pc_out, m_pc);
         check32(tag, "epc_out", epc_out, m_epc);
         check32(tag, "status_out", status_out, m_status);
         check32(tag, "cause_out", cause_out, m_cause);
      end
   endtask

   // monitor: pops the scoreboard whenever an entry is reported
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && entry_valid) begin
            if (expq.size() == 0) begin
               n_tests++; n_fail++;
               $display("FAIL R2 unexpected entry_valid: actual 1 expected 0");
            end else begin
               exp_t  e;
               string t;
               e = expq.pop_front();
               t = tagq.pop_front();
               check32(t, "pc_out", pc_out, e.pc);
               check32(t, "epc_out", epc_out, e.epc);
               check32(t, "errorepc_out", errorepc_out, e.errepc);
               check32(t, "status_out", status_out, e.status);
               check32(t, "cause_out", cause_out, e.cause);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         report();
      end
   end

   initial begin
      logic [4:0] codes [15];
      codes = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7,
                5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd15};
      repeat (3) @(negedge clk);
      // R1 reset state
      check32("R1", "pc_out", pc_out, 32'hBFC0_0000);
      check32("R1", "epc_out", epc_out, 32'd0);
      check32("R1", "errorepc_out", errorepc_out, 32'd0);
      check32("R1", "status_out", status_out, 32'd0);
      check32("R1", "cause_out", cause_out, 32'd0);
      check32("R1", "entry_valid", {31'b0, entry_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      fire(5'd8,  32'h0040_1000, 1'b0, 1'b0, 2'd0, 32'h0000_0010, 32'h0000_0000, 32'h8000_1234, "R4_R7_R8_syscall");
      fire(5'd9,  32'h0040_2000, 1'b1, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, "R8_delay");
      fire(5'd12, 32'h0040_3000, 1'b0, 1'b0, 2'd0, 32'h0000_0002, 32'h8000_0000, 32'h8000_0000, "R9_exl_set");
      fire(5'd0,  32'h0040_4000, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0400, 32'h9000_0000, "R5_iv_clear");
      fire(5'd0,  32'h0040_5000, 1'b1, 1'b0, 2'd0, 32'h0000_0000, 32'h0080_0400, 32'h9000_0000, "R5_iv_set");
      fire(5'd2,  32'h0040_6000, 1'b0, 1'b1, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, "R6_refill_load");
      fire(5'd3,  32'h0040_7000, 1'b0, 1'b1, 2'd0, 32'h0000_0002, 32'h0000_0000, 32'h8000_0000, "R6_refill_exl");
      fire(5'd2,  32'h0040_8000, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, "R6_no_refill");
      fire(5'd3,  32'h0040_9000, 1'b0, 1'b1, 2'd0, 32'h0040_0000, 32'h0000_0000, 32'h8000_0000, "R6_R7_bev_refill");
      fire(5'd4,  32'h0040_A000, 1'b0, 1'b0, 2'd0, 32'h0040_0000, 32'h0000_0000, 32'h8000_0000, "R7_bev_general");
      fire(5'd11, 32'h0040_B000, 1'b0, 1'b0, 2'd2, 32'h0000_0000, 32'h1000_0000, 32'h8000_0000, "R10_copu");
      fire(5'd13, 32'h0040_C000, 1'b0, 1'b0, 2'd1, 32'h0000_0000, 32'h3000_0300, 32'h8000_0000, "R10_R3_ce_kept");
      fire(5'd28, 32'h0040_D000, 1'b1, 1'b0, 2'd0, 32'h0000_0001, 32'h1234_5678, 32'h8000_0000, "R11_nmi");
      fire(5'd29, 32'h0040_E000, 1'b0, 1'b0, 2'd0, 32'h0000_0002, 32'h0000_0040, 32'h8000_0000, "R12_soft_reset");
      fire(5'd14, 32'h0040_F000, 1'b0, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 32'h8000_0000, "R2_ignored_14");
      fire(5'd31, 32'h0041_0000, 1'b1, 1'b0, 2'd0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, "R2_ignored_31");

      for (int i = 0; i < 24; i++) begin
         logic [31:0] st;
         st = $urandom() & 32'hFFFF_FFFB;
         fire(codes[$urandom_range(0, 14)], $urandom() & 32'hFFFF_FFFC, 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)), st, $urandom(), $urandom(),
              "R3_R8_R9_random");
      end

      // R13 idle hold
      repeat (6) @(negedge clk);
      check32("R13", "pc_out", pc_out, m_pc);
      check32("R13", "epc_out", epc_out, m_epc);
      check32("R13", "errorepc_out", errorepc_out, m_errepc);
      check32("R13", "status_out", status_out, m_status);
      check32("R13", "cause_out", cause_out, m_cause);
      // R2 every accepted strobe produced exactly one entry
      check32("R2", "pending entries", 32'(expq.size()), 32'd0);
      finished = 1'b1;
      report();
   end

endmodule